// File: doc/BRIEF.md
# Wake-Source Flag Register

This block is a 16-bit status and control word that records which events have been seen on the chip's wake inputs. It also carries a pin-hold bit, which freezes the I/O pins while the chip leaves its deepest low-power state. Eight external interrupt lines, a non-maskable interrupt and a manual-reset request each set a sticky flag when they pulse. The pulses count whenever they occur, in normal operation as well as in standby. A strobe marking entry into deep standby sets the pin-hold bit, and the `pin_hold` output drives the external pin retention logic directly.

Software reads and writes the word through a plain strobe port. A flag can only be cleared in two steps. First a full-word read must return 1 in that bit, which arms it. Then a full-word write with 0 in that position clears it. A hardware set always beats a clear in the same cycle, so no wake event is lost. Only the external pin reset (`rst_n`) empties the word. Warm resets (`warm_rst`, which covers watchdog and manual resets) keep the contents. After a manual-reset request has been recorded, interrupt lines stop setting their flags until software clears that flag.

Top module: `wake_flag_reg`

## Requirements
- R1: While `rst_n` is low, `reg_q` is 0x0000 and `pin_hold` is 0. It stays that way after release until an event arrives, and every bit is disarmed.
- R2: Bit layout: bit 15 is pin-hold, bit 9 is the manual-reset flag, bit 8 is the NMI flag, and bits 7..0 are the IRQ7..IRQ0 flags. Bits 14..10 always read 0, and writing them has no effect.
- R3: A pulse on `irq_pulse[i]` or `nmi_pulse` sets its flag on the next clock edge. This happens in any operating state.
- R4: `mres_req` sets bit 9. IRQ pulses do not set IRQ flags in these two cases: while bit 9 is 1, or in the same cycle as `mres_req`. NMI is not blocked.
- R5: `dstby_enter` sets bit 15. `pin_hold` equals bit 15 and stays high until software clears that bit.
- R6: A word write (`bus_wr` with `bus_word`=1) clears bit i only if wdata[i] is 0 and bit i is armed. A write never sets a bit.
- R7: Bit i becomes armed when a word read (`bus_rd` with `bus_word`=1) sees it at 1. Any word write disarms every bit, applying its clear first. A write issued in the same cycle as a read takes precedence over the read's arming.
- R8: Byte accesses (`bus_word`=0) are ignored. They do not arm bits, do not clear bits and do not disarm bits.
- R9: `warm_rst` leaves every bit of `reg_q` unchanged and disarms every bit.
- R10: When a hardware set and a software clear hit the same bit in the same cycle, the bit ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous cold reset from the external reset pin, active low |
| warm_rst | input | 1 | Watchdog or manual reset; keeps contents and disarms bits |
| irq_pulse | input | 8 | Synchronised single-cycle external interrupt pulses |
| nmi_pulse | input | 1 | Synchronised non-maskable interrupt pulse |
| mres_req | input | 1 | Manual-reset wake request pulse |
| dstby_enter | input | 1 | Strobe marking entry into deep standby |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_word | input | 1 | 1 = full 16-bit access, 0 = byte access |
| bus_wdata | input | 16 | Write data |
| reg_q | output | 16 | Register value, also the read data |
| pin_hold | output | 1 | Pin retention control |

## Verification
The hardest state to reach is a bit that is armed at the exact moment a hardware set lands on it. The bench gets there with a word read while pin-hold is 1, then a write of 0 in the same cycle as `dstby_enter`, and it expects the bit to survive. The stimulus also separates read arming from write disarming. It places byte reads and byte writes between word operations and inserts a warm reset between a read and its write, so that a wrong arming rule shows up as a bit that clears when it should not, or stays set when it should clear.

// File: rtl/wfr_pkg.sv
package wfr_pkg;
  localparam int WFR_W    = 16;
  localparam int WFR_NIRQ = 8;

  // Mask of the bits that hold state for a given width and IRQ count.
  function automatic logic [WFR_W-1:0] wfr_impl_mask(input int nirq);
    logic [WFR_W-1:0] m;
    m = '0;
    for (int i = 0; i < nirq; i++) m[i] = 1'b1;
    m[nirq]     = 1'b1;
    m[nirq + 1] = 1'b1;
    m[WFR_W-1]  = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/wfr_event_merge.sv
module wfr_event_merge #(
  parameter int W    = wfr_pkg::WFR_W,
  parameter int NIRQ = wfr_pkg::WFR_NIRQ
) (
  input  logic [NIRQ-1:0] irq_pulse,
  input  logic            nmi_pulse,
  input  logic            mres_req,
  input  logic            dstby_enter,
  input  logic            mres_flag,
  output logic [W-1:0]    set_vec
);
  localparam int NMI_POS  = NIRQ;
  localparam int MRES_POS = NIRQ + 1;
  localparam int HOLD_POS = W - 1;

  logic irq_block;

  // A recorded or arriving manual-reset wake masks interrupt flags
  assign irq_block = mres_flag | mres_req;

  always_comb begin
    set_vec           = '0;
    set_vec[NIRQ-1:0] = irq_block ? '0 : irq_pulse;
    set_vec[NMI_POS]  = nmi_pulse;
    set_vec[MRES_POS] = mres_req;
    set_vec[HOLD_POS] = dstby_enter;
  end
endmodule

// File: rtl/wfr_arm_track.sv
module wfr_arm_track #(
  parameter int W = wfr_pkg::WFR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         warm_rst,
  input  logic         rd_word,
  input  logic         wr_word,
  input  logic [W-1:0] reg_q,
  output logic [W-1:0] armed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= '0;
    end else if (warm_rst || wr_word) begin
      armed <= '0;
    end else if (rd_word) begin
      armed <= armed | reg_q;
    end
  end
endmodule

// File: rtl/wfr_bit_cell.sv
module wfr_bit_cell #(
  parameter bit IMPL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  logic q_next;

  // Set takes priority over clear; unimplemented cells stay at 0
  assign q_next = (set_i | (q & ~clr_i)) & IMPL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_next;
  end
endmodule

// File: rtl/wake_flag_reg.sv
module wake_flag_reg #(
  parameter int W    = wfr_pkg::WFR_W,
  parameter int NIRQ = wfr_pkg::WFR_NIRQ
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            warm_rst,
  input  logic [NIRQ-1:0] irq_pulse,
  input  logic            nmi_pulse,
  input  logic            mres_req,
  input  logic            dstby_enter,
  input  logic            bus_rd,
  input  logic            bus_wr,
  input  logic            bus_word,
  input  logic [W-1:0]    bus_wdata,
  output logic [W-1:0]    reg_q,
  output logic            pin_hold
);
  localparam int          MRES_POS  = NIRQ + 1;
  localparam int          HOLD_POS  = W - 1;
  localparam logic [W-1:0] IMPL_MASK = wfr_pkg::wfr_impl_mask(NIRQ);

  logic         rd_word, wr_word;
  logic [W-1:0] set_vec, clr_vec, armed;

  assign rd_word = bus_rd & bus_word;
  assign wr_word = bus_wr & bus_word;

  wfr_event_merge #(.W(W), .NIRQ(NIRQ)) merge_i (
    .irq_pulse   (irq_pulse),
    .nmi_pulse   (nmi_pulse),
    .mres_req    (mres_req),
    .dstby_enter (dstby_enter),
    .mres_flag   (reg_q[MRES_POS]),
    .set_vec     (set_vec)
  );

  wfr_arm_track #(.W(W)) arm_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .warm_rst (warm_rst),
    .rd_word  (rd_word),
    .wr_word  (wr_word),
    .reg_q    (reg_q),
    .armed    (armed)
  );

  // Zero written over an armed bit requests a clear
  assign clr_vec = wr_word ? (~bus_wdata & armed) : '0;

  for (genvar b = 0; b < W; b++) begin : g_cell
    wfr_bit_cell #(.IMPL(IMPL_MASK[b])) cell_i (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_vec[b]),
      .clr_i (clr_vec[b]),
      .q     (reg_q[b])
    );
  end

  assign pin_hold = reg_q[HOLD_POS];
endmodule

// File: rtl/wfr_chk.sv
module wfr_chk #(
  parameter int W    = wfr_pkg::WFR_W,
  parameter int NIRQ = wfr_pkg::WFR_NIRQ
) (
  input logic            clk,
  input logic            rst_n,
  input logic            warm_rst,
  input logic [NIRQ-1:0] irq_pulse,
  input logic            nmi_pulse,
  input logic            mres_req,
  input logic            dstby_enter,
  input logic            bus_rd,
  input logic            bus_wr,
  input logic            bus_word,
  input logic [W-1:0]    bus_wdata,
  input logic [W-1:0]    reg_q,
  input logic            pin_hold
);
  localparam int NMI_POS  = NIRQ;
  localparam int MRES_POS = NIRQ + 1;
  localparam int HOLD_POS = W - 1;

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_q[HOLD_POS-1:MRES_POS+1] == '0);

  // R3
  nmi_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pulse |=> reg_q[NMI_POS]);

  // R4
  irq_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_q[MRES_POS] |=> ((reg_q[NIRQ-1:0] & ~$past(reg_q[NIRQ-1:0])) == '0));

  // R5
  hold_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dstby_enter |=> pin_hold);

  // R5
  hold_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_hold && !dstby_enter) |=> !pin_hold);

  // R8
  no_word_write_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_word) |=> (($past(reg_q) & ~reg_q) == '0));
endmodule

bind wake_flag_reg wfr_chk #(.W(W), .NIRQ(NIRQ)) chk_i (.*);

// File: tb/wake_flag_reg_tb_top.sv
`timescale 1ns/100ps
module wake_flag_reg_tb_top;
  typedef struct {
    logic [15:0] val;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        warm_rst = 1'b0;
  logic [7:0]  irq_pulse = '0;
  logic        nmi_pulse = 1'b0;
  logic        mres_req = 1'b0;
  logic        dstby_enter = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_word = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] reg_q;
  logic        pin_hold;

  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  wake_flag_reg dut_i (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .irq_pulse(irq_pulse),
    .nmi_pulse(nmi_pulse), .mres_req(mres_req), .dstby_enter(dstby_enter),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .reg_q(reg_q), .pin_hold(pin_hold)
  );

  // Driver: applies one cycle of stimulus and queues the value expected after the edge
  task automatic op(input logic rd, input logic wr, input logic word,
                    input logic [15:0] wd, input logic [7:0] irq,
                    input logic nmi, input logic mres, input logic dstby,
                    input logic warm, input logic [15:0] exp_val, input string tag);
    exp_t e;
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_word = word; bus_wdata = wd;
    irq_pulse = irq; nmi_pulse = nmi; mres_req = mres;
    dstby_enter = dstby; warm_rst = warm;
    e.val = exp_val; e.tag = tag;
    sb_q.push_back(e);
    @(posedge clk);
  endtask

  task automatic idle(input logic [15:0] exp_val, input string tag);
    op(0, 0, 0, 16'h0, 8'h0, 0, 0, 0, 0, exp_val, tag);
  endtask

  task automatic rd_w(input logic [15:0] exp_val, input string tag);
    op(1, 0, 1, 16'h0, 8'h0, 0, 0, 0, 0, exp_val, tag);
  endtask

  task automatic wr_w(input logic [15:0] wd, input logic [15:0] exp_val, input string tag);
    op(0, 1, 1, wd, 8'h0, 0, 0, 0, 0, exp_val, tag);
  endtask

  // Monitor: compares each result just after the edge it belongs to
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (reg_q !== e.val || pin_hold !== e.val[15]) begin
        fails++;
        $display("FAIL %s: reg_q=%h pin_hold=%b expected reg_q=%h pin_hold=%b",
                 e.tag, reg_q, pin_hold, e.val, e.val[15]);
      end
    end
  end

  task automatic direct_check(input logic [15:0] exp_val, input string tag);
    checks++;
    if (reg_q !== exp_val || pin_hold !== exp_val[15]) begin
      fails++;
      $display("FAIL %s: reg_q=%h pin_hold=%b expected reg_q=%h pin_hold=%b",
               tag, reg_q, pin_hold, exp_val, exp_val[15]);
    end
  endtask

  initial begin
    #1;
    direct_check(16'h0000, "R1 in reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(16'h0000, "R1 after release");
    // R3: flags set in normal operation
    op(0, 0, 0, 16'h0, 8'h05, 0, 0, 0, 0, 16'h0005, "R3 irq0/irq2");
    op(0, 0, 0, 16'h0, 8'h00, 1, 0, 0, 0, 16'h0105, "R3 nmi");
    // R6: write without prior read does not clear
    wr_w(16'h0000, 16'h0105, "R6 unarmed write");
    rd_w(16'h0105, "R7 word read arms");
    wr_w(16'hFFFE, 16'h0104, "R6 clear bit0 only, ones do not set");
    wr_w(16'h0000, 16'h0104, "R7 write disarmed all");
    // R8: byte read does not arm
    op(1, 0, 0, 16'h0, 8'h0, 0, 0, 0, 0, 16'h0104, "R8 byte read");
    wr_w(16'h0000, 16'h0104, "R8 byte read did not arm");
    // R8: byte write neither clears nor disarms
    rd_w(16'h0104, "R7 rearm");
    op(0, 1, 0, 16'h0000, 8'h0, 0, 0, 0, 0, 16'h0104, "R8 byte write ignored");
    wr_w(16'h0000, 16'h0000, "R8 arm kept across byte write");
    wr_w(16'hFFFF, 16'h0000, "R2 R6 ones write sets nothing");
    // R5: deep standby entry
    op(0, 0, 0, 16'h0, 8'h0, 0, 0, 1, 0, 16'h8000, "R5 hold set");
    // R9: warm reset keeps contents and disarms
    op(0, 0, 0, 16'h0, 8'h0, 0, 0, 0, 1, 16'h8000, "R9 warm keeps");
    rd_w(16'h8000, "R9 arm hold");
    op(0, 0, 0, 16'h0, 8'h0, 0, 0, 0, 1, 16'h8000, "R9 warm pulse");
    wr_w(16'h0000, 16'h8000, "R9 warm disarmed");
    // R10: set wins
    rd_w(16'h8000, "R10 arm hold");
    op(0, 1, 1, 16'h0000, 8'h0, 0, 0, 1, 0, 16'h8000, "R10 set beats clear");
    rd_w(16'h8000, "R5 rearm");
    wr_w(16'h0000, 16'h0000, "R5 hold released");
    // R4: manual reset blocks IRQ but not NMI
    op(0, 0, 0, 16'h0, 8'h0, 0, 1, 0, 0, 16'h0200, "R4 mres flag");
    op(0, 0, 0, 16'h0, 8'hFF, 0, 0, 0, 0, 16'h0200, "R4 irq blocked");
    op(0, 0, 0, 16'h0, 8'h00, 1, 0, 0, 0, 16'h0300, "R4 nmi not blocked");
    rd_w(16'h0300, "R4 arm");
    wr_w(16'h0000, 16'h0000, "R4 clear all");
    op(0, 0, 0, 16'h0, 8'h80, 0, 1, 0, 0, 16'h0200, "R4 same-cycle block");
    rd_w(16'h0200, "R4 arm mres");
    wr_w(16'h0000, 16'h0000, "R4 clear mres");
    op(0, 0, 0, 16'h0, 8'h80, 0, 0, 0, 0, 16'h0080, "R3 irq7 after unblock");
    // R7: read and write in the same cycle, write wins
    op(1, 1, 1, 16'h0000, 8'h0, 0, 0, 0, 0, 16'h0080, "R7 rd+wr same cycle");
    wr_w(16'h0000, 16'h0080, "R7 same-cycle read did not arm");
    op(0, 0, 0, 16'h0, 8'h0, 0, 0, 1, 0, 16'h8080, "R5 hold again");
    idle(16'h8080, "R1 before cold reset");
    // R1: cold reset clears
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    direct_check(16'h0000, "R1 cold reset");
    @(negedge clk);
    rst_n = 1'b1;
    wr_w(16'h0000, 16'h0000, "R1 idle after cold reset");
    idle(16'h0000, "R1 final");
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
      end
    join_any
    #1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule